// File: doc/BRIEF.md
# Successive-Approximation Sequencer with Repeated Final Comparison

This block is the digital controller of a successive-approximation converter that trades conversion time for noise reduction. It is clocked from a master clock running 32 times the sample rate. Each conversion is a fixed 32-cycle frame. The first four cycles hold the input-sampling enable high. The next eleven cycles resolve one capacitor each, most significant first. The final seventeen cycles leave the capacitor array untouched and keep strobing the comparator at the residue left after the last step, counting how many of those decisions come back as one.

The capacitor array uses a redundant, non-binary weighting. Listed from the least significant position upward, the weights are 1, 1, 2, 4, 8, 16, 16, 32, 64, 128 and 256, which sum to 528 units. The repeated 16-unit step lets later steps recover from an early wrong decision. At the end of each frame the block reports two results: the decided code, expressed as a signed offset from mid-scale, and the ones count k. Downstream logic can use k to estimate the residue.

Top module: `sar_rep_seq`

## Requirements
- R1: A frame lasts exactly 32 clock cycles. `done_o` is high for exactly one cycle per frame: the first cycle of the following frame, which is the first sampling cycle.
- R2: `sample_en_o` is high in frame cycles 1 to 4 and low in cycles 5 to 32.
- R3: Throughout the sampling cycles, `dac_ctl_o` holds the mid-scale setting. In that setting only bit 10, the 256-unit capacitor, is 1.
- R4: In frame cycle 5+s, for s from 0 to 10, decision step s acts on control bit 10-s. The bits above it hold the earlier decisions, bit 10-s is 1 as the trial, and the bits below it are 0. A comparator 1 sampled at the end of that cycle keeps the bit; a 0 clears it.
- R5: Control bit p has weight 1 for p=0, 2^(p-1) for p from 1 to 5, and 2^(p-2) for p from 6 to 10. With an ideal comparator that returns 1 when the input is at least the DAC level, any integer input from 0 to 528 resolves to a DAC level equal to that input.
- R6: `raw_code_o` is a two's-complement value equal to the weighted sum of the final control bits minus 264.
- R7: `dac_ctl_o` does not change during frame cycles 16 to 32.
- R8: `ones_k_o` equals the number of comparator ones sampled at the ends of frame cycles 16 to 32, so it lies in the range 0 to 17. Comparator values in the sampling and decision cycles do not count.
- R9: The ones count restarts from zero in every frame, so k never carries over from the previous frame.
- R10: `raw_code_o` and `ones_k_o` hold their values from one `done_o` pulse until the next.
- R11: A low `rst_n` at a clock edge, even in the middle of a frame, returns the block to frame cycle 1. After reset, `dac_ctl_o` is at mid-scale and `raw_code_o`, `ones_k_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 cycles per sample |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_i | input | 1 | Comparator decision, 1 when input is at or above DAC level |
| sample_en_o | output | 1 | Input-sampling enable |
| dac_ctl_o | output | 11 | Capacitor control word, bit 10 is the 256-unit capacitor |
| raw_code_o | output | 10 | Signed code relative to mid-scale, two's complement |
| ones_k_o | output | 5 | Ones counted in the repeated comparisons |
| done_o | output | 1 | One-cycle pulse marking new results |

## Verification
Every integer input from 0 to 528 is converted through a behavioural comparator. This sweep reaches both ends of the range, including the top code, which only resolves correctly if the duplicated 16-unit step is weighted as 16. If either copy were weighted 32, or the trial bit were placed one position off, some inputs would settle on a neighbouring code and the per-step control-word checks would fail.

In the repeat cycles the comparator is driven with a scrambled pattern whose ones count walks through every value from 0 to 17. It is driven high throughout the sampling cycles and follows the ideal comparator through the decision cycles. A counter enabled one cycle early or one cycle late, or one that misses the final strobe, would report k off by one. A counter that is not cleared between frames would accumulate across frames.

A reset in the middle of a frame checks that the sequence restarts at the sampling phase with the array at mid-scale, instead of resuming from the step where it was interrupted.

// File: rtl/sar_rep_pkg.sv
// Package: capacitor weighting shared by the sequencer modules.
// Assumes positions are numbered from the LSB (0) upward and that the
// position DUP and DUP+1 share the same weight (the redundant step).
package sar_rep_pkg;

    // Weight in units of the capacitor at position p.
    function automatic int unsigned cap_weight(int unsigned p, int unsigned dup);
        if (p == 0)
            return 1;
        else if (p <= dup)
            return 32'd1 << (p - 1);
        else
            return 32'd1 << (p - 2);
    endfunction

    // Sum of all capacitor weights for an n-capacitor array.
    function automatic int unsigned cap_total(int unsigned n, int unsigned dup);
        int unsigned acc;
        acc = 0;
        for (int unsigned p = 0; p < n; p++)
            acc += cap_weight(p, dup);
        return acc;
    endfunction

endpackage

// File: rtl/sar_rep_phase.sv
// Frame phase counter. Counts 0..CONV_CYC-1 and decodes the three phases:
// sampling, bit decisions and repeated comparisons.
// Assumes synchronous active-low reset returns the frame to its first cycle.
module sar_rep_phase #(
    parameter int SAMPLE_CYC = 4,
    parameter int NBITS      = 11,
    parameter int REPEAT_CYC = 17,
    localparam int CONV_CYC  = SAMPLE_CYC + NBITS + REPEAT_CYC,
    localparam int PH_W      = $clog2(CONV_CYC),
    localparam int STEP_W    = $clog2(NBITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PH_W-1:0]   ph_o,
    output logic              sample_en_o,
    output logic              step_valid_o,
    output logic [STEP_W-1:0] step_o,
    output logic              rep_en_o,
    output logic              last_o
);

    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(CONV_CYC - 1);
    localparam logic [PH_W-1:0] PH_SAMP  = PH_W'(SAMPLE_CYC);
    localparam logic [PH_W-1:0] PH_REP   = PH_W'(SAMPLE_CYC + NBITS);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] step_full;

    // Advance the frame position, wrapping after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= '0;
        else if (ph_q == PH_LAST)
            ph_q <= '0;
        else
            ph_q <= ph_q + 1'b1;
    end

    // Decode the phase windows from the frame position.
    always_comb begin
        step_full    = ph_q - PH_SAMP;
        sample_en_o  = (ph_q < PH_SAMP);
        step_valid_o = (ph_q >= PH_SAMP) && (ph_q < PH_REP);
        step_o       = step_full[STEP_W-1:0];
        rep_en_o     = (ph_q >= PH_REP);
        last_o       = (ph_q == PH_LAST);
    end

    assign ph_o = ph_q;

    // R1: the frame wraps to its first cycle after the last one.
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_LAST) |=> (ph_q == '0));

    // R1: inside a frame the position advances by exactly one.
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_LAST) |=> (ph_q == $past(ph_q) + 1'b1));

endmodule

// File: rtl/sar_rep_dac.sv
// Capacitor control register. One flop per capacitor: it is loaded with the
// trial value one step before its own decision, then takes the comparator
// result during its decision step and holds it to the end of the frame.
// Also forms the weighted sum of the control word in units.
// Assumes the MSB trial is the mid-scale setting loaded at reset/frame end.
module sar_rep_dac
    import sar_rep_pkg::*;
#(
    parameter int NBITS    = 11,
    parameter int DUP_POS  = 5,
    localparam int STEP_W  = $clog2(NBITS),
    localparam int TOTAL   = int'(cap_total(NBITS, DUP_POS)),
    localparam int SUM_W   = $clog2(TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_i,
    input  logic              step_valid_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              cmp_i,
    output logic [NBITS-1:0]  ctl_o,
    output logic [SUM_W-1:0]  sum_o
);

    logic [NBITS-1:0] ctl_q;

    for (genvar p = 0; p < NBITS; p++) begin : g_cap
        localparam int STEP_OWN = NBITS - 1 - p;
        localparam logic MID_BIT = (p == NBITS - 1);

        if (p == NBITS - 1) begin : g_msb
            // Top capacitor: mid-scale trial at frame start, then its decision.
            always_ff @(posedge clk) begin
                if (!rst_n || last_i)
                    ctl_q[p] <= MID_BIT;
                else if (step_valid_i && step_i == STEP_W'(STEP_OWN))
                    ctl_q[p] <= cmp_i;
            end
        end else begin : g_low
            // Lower capacitor: trial set after the step above, then its decision.
            always_ff @(posedge clk) begin
                if (!rst_n || last_i)
                    ctl_q[p] <= MID_BIT;
                else if (step_valid_i && step_i == STEP_W'(STEP_OWN))
                    ctl_q[p] <= cmp_i;
                else if (step_valid_i && step_i == STEP_W'(STEP_OWN - 1))
                    ctl_q[p] <= 1'b1;
            end
        end
    end

    // Weighted sum of the present control word.
    always_comb begin
        logic [31:0] acc;
        acc = '0;
        for (int p = 0; p < NBITS; p++)
            if (ctl_q[p])
                acc = acc + cap_weight(p, DUP_POS);
        sum_o = acc[SUM_W-1:0];
    end

    assign ctl_o = ctl_q;

    // R4: bits below the current step stay cleared during the decisions.
    a_r4_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_i && step_i == '0) |-> (ctl_q == {1'b1, {(NBITS-1){1'b0}}}));

endmodule

// File: rtl/sar_rep_ones.sv
// Ones counter for the repeated comparisons. Cleared at the end of each frame
// and incremented only while the repeat window is enabled.
// Assumes clr and en are decoded from the same frame counter.
module sar_rep_ones #(
    parameter int REPEAT_CYC = 17,
    localparam int K_W       = $clog2(REPEAT_CYC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           en_i,
    input  logic           cmp_i,
    output logic [K_W-1:0] cnt_o
);

    logic [K_W-1:0] cnt_q;

    // Count comparator ones inside the repeat window only.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt_q <= '0;
        else if (en_i && cmp_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R8: the running count never exceeds the number of repeats.
    a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= K_W'(REPEAT_CYC)));

    // R9: a clear leaves the count at zero for the next frame.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/sar_rep_seq.sv
// Successive-approximation sequencer with repeated final comparisons.
// Sequences sampling, redundant-weight bit decisions and a run of repeated
// comparisons at the final residue, then publishes the signed code and the
// ones count with a one-cycle done pulse.
// Assumes the comparator output is stable at each rising clock edge.
module sar_rep_seq
    import sar_rep_pkg::*;
#(
    parameter int NBITS      = 11,
    parameter int SAMPLE_CYC = 4,
    parameter int REPEAT_CYC = 17,
    parameter int DUP_POS    = 5,
    localparam int TOTAL     = int'(cap_total(NBITS, DUP_POS)),
    localparam int MID_UNITS = TOTAL / 2,
    localparam int SUM_W     = $clog2(TOTAL + 1),
    localparam int CODE_W    = SUM_W,
    localparam int K_W       = $clog2(REPEAT_CYC + 1),
    localparam int CONV_CYC  = SAMPLE_CYC + NBITS + REPEAT_CYC,
    localparam int PH_W      = $clog2(CONV_CYC),
    localparam int STEP_W    = $clog2(NBITS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmp_i,
    output logic                     sample_en_o,
    output logic [NBITS-1:0]         dac_ctl_o,
    output logic signed [CODE_W-1:0] raw_code_o,
    output logic [K_W-1:0]           ones_k_o,
    output logic                     done_o
);

    localparam logic [NBITS-1:0] MID_CTL = {1'b1, {(NBITS-1){1'b0}}};

    logic [PH_W-1:0]   ph;
    logic              step_valid;
    logic [STEP_W-1:0] step;
    logic              rep_en;
    logic              last;
    logic [SUM_W-1:0]  code_sum;
    logic [K_W-1:0]    ones_cnt;

    logic [CODE_W-1:0] raw_q;
    logic [K_W-1:0]    k_q;
    logic              done_q;

    sar_rep_phase #(
        .SAMPLE_CYC (SAMPLE_CYC),
        .NBITS      (NBITS),
        .REPEAT_CYC (REPEAT_CYC)
    ) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .ph_o         (ph),
        .sample_en_o  (sample_en_o),
        .step_valid_o (step_valid),
        .step_o       (step),
        .rep_en_o     (rep_en),
        .last_o       (last)
    );

    sar_rep_dac #(
        .NBITS   (NBITS),
        .DUP_POS (DUP_POS)
    ) u_dac (
        .clk          (clk),
        .rst_n        (rst_n),
        .last_i       (last),
        .step_valid_i (step_valid),
        .step_i       (step),
        .cmp_i        (cmp_i),
        .ctl_o        (dac_ctl_o),
        .sum_o        (code_sum)
    );

    sar_rep_ones #(
        .REPEAT_CYC (REPEAT_CYC)
    ) u_ones (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (last),
        .en_i  (rep_en),
        .cmp_i (cmp_i),
        .cnt_o (ones_cnt)
    );

    // Publish code and count at the frame end, including the final strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            k_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (last) begin
                raw_q <= code_sum - SUM_W'(MID_UNITS);
                k_q   <= ones_cnt + K_W'(cmp_i);
            end
        end
    end

    assign raw_code_o = raw_q;
    assign ones_k_o   = k_q;
    assign done_o     = done_q;

    // R1: the done pulse lands in the first cycle of a frame.
    a_r1_done_first: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (ph == '0));

    // R3: the array sits at mid-scale while the input is sampled.
    a_r3_mid_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_o |-> (dac_ctl_o == MID_CTL));

    // R7: no switching after the last decision has landed.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ph > PH_W'(SAMPLE_CYC + NBITS)) |-> $stable(dac_ctl_o));

    // R6: the published code stays within half the array range.
    a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(raw_code_o) >= -MID_UNITS) && (int'(raw_code_o) <= MID_UNITS));

    // R10: results change only on the edge that raises done.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |=> (done_q || ($stable(raw_q) && $stable(k_q))));

endmodule

// File: tb/sar_rep_seq_tb.sv
// Exhaustive sweep of every integer input 0..528 through a behavioural
// comparator, with a scripted repeat-phase pattern and a mid-frame reset.
module sar_rep_seq_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp;
    logic              sample_en;
    logic [10:0]       ctl;
    logic signed [9:0] raw;
    logic [4:0]        k;
    logic              done;

    int nchk = 0;
    int nfail = 0;
    int bph = 0;
    int vin = 0;
    int prev = 0;
    int vin_idx = 0;
    int last_raw = 0;
    int last_k = 0;
    int ctl15 = 0;
    bit have_prev = 0;
    bit have_res = 0;
    bit just_reset = 0;
    bit sweep_done = 0;

    localparam int MID_CTL = 1024;

    always #4 clk = ~clk;

    sar_rep_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_i       (cmp),
        .sample_en_o (sample_en),
        .dac_ctl_o   (ctl),
        .raw_code_o  (raw),
        .ones_k_o    (k),
        .done_o      (done)
    );

    // Weight of control bit p per R5.
    function automatic int wt(int p);
        if (p == 0) return 1;
        if (p <= 5) return 1 << (p - 1);
        return 1 << (p - 2);
    endfunction

    function automatic int lvl(logic [10:0] c);
        int acc = 0;
        for (int p = 0; p < 11; p++) if (c[p]) acc += wt(p);
        return acc;
    endfunction

    // Expected control word at decision step s (s = 11: after all steps).
    function automatic int exp_ctl(int v, int s);
        int rc = 0;
        int c = 0;
        for (int t = 0; t < s; t++) begin
            if (v >= rc + wt(10 - t)) begin
                c = c | (1 << (10 - t));
                rc += wt(10 - t);
            end
        end
        if (s < 11) c = c | (1 << (10 - s));
        return c;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (bph=%0d vin=%0d)", req, act, expv, bph, vin);
        end
    endtask

    // Bench copy of the frame position, from R1.
    always @(posedge clk) begin
        if (!rst_n) bph <= 0;
        else        bph <= (bph == 31) ? 0 : bph + 1;
    end

    // Behavioural comparator: noise in sampling, ideal in decisions, pattern in repeats.
    always_comb begin
        if (bph < 4)
            cmp = 1'b1;
        else if (bph < 15)
            cmp = (vin >= lvl(ctl));
        else
            cmp = ((((bph - 15) * 7) % 17) < (vin % 18));
    end

    // Output checks, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            if (have_prev && !sweep_done) vin_idx--;
            have_prev  = 0;
            have_res   = 0;
            just_reset = 1;
        end else begin
            chk(sample_en == (bph < 4), "R2 sample_en", int'(sample_en), int'(bph < 4));
            chk(done == (bph == 0 && have_prev), "R1 done", int'(done), int'(bph == 0 && have_prev));
            if (bph == 0) begin
                if (just_reset) begin
                    chk(raw == 0, "R11 raw after reset", int'(raw), 0);
                    chk(k == 0, "R11 k after reset", int'(k), 0);
                    chk(ctl == MID_CTL, "R11 ctl after reset", int'(ctl), MID_CTL);
                    just_reset = 0;
                end
                if (have_prev) begin
                    chk(int'(raw) == prev - 264, "R6 raw code", int'(raw), prev - 264);
                    chk(int'(k) == prev % 18, "R8 R9 ones count", int'(k), prev % 18);
                    last_raw = prev - 264;
                    last_k   = prev % 18;
                    have_res = 1;
                end
                if (vin_idx > 528) begin
                    sweep_done = 1;
                    have_prev  = 0;
                end else begin
                    vin       = vin_idx;
                    prev      = vin;
                    vin_idx++;
                    have_prev = 1;
                end
            end
            if (bph == 2)
                chk(ctl == MID_CTL, "R3 mid-scale in sampling", int'(ctl), MID_CTL);
            if (bph >= 4 && bph <= 14)
                chk(int'(ctl) == exp_ctl(vin, bph - 4), "R4 trial word", int'(ctl), exp_ctl(vin, bph - 4));
            if (bph == 10 && have_res) begin
                chk(int'(raw) == last_raw, "R10 raw held", int'(raw), last_raw);
                chk(int'(k) == last_k, "R10 k held", int'(k), last_k);
            end
            if (bph == 15) ctl15 = int'(ctl);
            if (bph == 20 || bph == 31)
                chk(int'(ctl) == ctl15, "R7 ctl frozen", int'(ctl), ctl15);
            if (bph == 20)
                chk(lvl(ctl) == vin, "R5 resolved level", lvl(ctl), vin);
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    // Stimulus: reset, exhaustive sweep, mid-frame reset.
    initial begin
        repeat (3) @(posedge clk);
        #3;
        chk(sample_en == 1'b1, "R11 sample_en in reset", int'(sample_en), 1);
        chk(done == 1'b0, "R11 done in reset", int'(done), 0);
        chk(ctl == MID_CTL, "R3 R11 ctl in reset", int'(ctl), MID_CTL);
        chk(raw == 0 && k == 0, "R11 results in reset", int'(raw) + int'(k), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        wait (vin_idx == 200);
        do begin
            @(posedge clk);
            #1;
        end while (bph != 9);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        wait (sweep_done);
        repeat (2) @(posedge clk);
        summary();
        $finish;
    end

endmodule